// File: doc/BRIEF.md
# Shared Interrupt Status and Test-Forcing Registers

This block is the common interrupt register file of a four-channel SPI controller. Each channel's transfer logic sends it one-cycle pulses when its transmit holding register empties or its receive holding register fills. Each pulse sets a sticky status bit. Software picks which status bits may raise the single level-sensitive interrupt line through an enable register. It acknowledges events by writing ones to the status register.

A built-in self-test path lets software drive every defined status bit high in one write. This checks the interrupt wiring without running transfers. While that test path is armed, acknowledge writes are refused so that the forced pattern stays in place. The block also holds a system configuration register, a wakeup-enable bit, a fixed revision word and a reset-complete indicator. All of these sit on a 32-bit register bus with byte offsets. A write to the configuration register can request a soft reset of the whole register set.

Top module: `spi_irq_regs`

## Requirements
- R1: A pulse on `tx_evt[n]` sets status bit 4n and a pulse on `rx_evt[n]` sets status bit 4n+2. The bit reads as set from the cycle after the pulse.
- R2: A write to the enable register (offset 0x1C) stores the written value ANDed with 0x0001777F.
- R3: `irq_out` is high exactly when some bit is set in both the status register and the enable register. It follows any change of either register one cycle after the causing edge input.
- R4: A write to the status register (offset 0x18) clears each status bit written as one and leaves the others as they were. With no write and no event, status holds its value.
- R5: A status write has no effect while control bit 3 and test bit 11 are both set.
- R6: Forcing ORs 0x0001777F into status. It happens on a test write (offset 0x24) with data bit 11 set while control bit 3 is already set. It also happens on a control write (offset 0x28) with data bit 3 set while test bit 11 is already set. The same writes without the other bit already set do not force.
- R7: Test writes keep data bits 11:0, control writes keep bits 3:0 and wakeup writes (offset 0x20) keep bit 0. After reset, control reads 4 and status, enable, test and wakeup read 0.
- R8: A configuration write (offset 0x10) with data bit 1 set returns every register to its reset value, and any event in that cycle is dropped. The configuration register itself stores the data ANDed with 0x31D.
- R9: Offset 0x00 reads 0x91 and offset 0x14 reads 1.
- R10: When an event pulse and a status write that clears the same bit land in one cycle, the bit ends up set.
- R11: Offsets not listed above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with clk |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_evt | input | NCH | Per-channel transmit-empty event pulses |
| rx_evt | input | NCH | Per-channel receive-full event pulses |
| irq_out | output | 1 | Level interrupt request |

## Verification
An event pulse from a channel and a software acknowledge write can both touch the status register in the same clock. The bench provokes this by raising a transmit-empty pulse in the very cycle it writes a one to clear that same status bit. It then reads status back and expects the bit set. Forcing and acknowledge also meet, because a clear issued while both test bits are armed must leave the forced pattern whole. Event pulses are also dropped when they land in the cycle of a soft reset.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_REV     = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG     = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RSTDONE = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ISTAT   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IEN     = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_WAKE    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_TEST    = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h28;

  localparam logic [DATA_W-1:0] STAT_MASK = 32'h0001_777F;
  localparam logic [DATA_W-1:0] CFG_MASK  = 32'h0000_031D;
  localparam logic [DATA_W-1:0] REV_VAL   = 32'h0000_0091;

  localparam int TEST_W         = 12;
  localparam int CTRL_W         = 4;
  localparam int TEST_FORCE_BIT = 11;
  localparam int CTRL_FORCE_BIT = 3;
  localparam int CFG_SRST_BIT   = 1;
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'h4;

  typedef struct packed {
    logic cfg;
    logic istat;
    logic ien;
    logic wake;
    logic test;
    logic ctrl;
  } wr_sel_t;
endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
(
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output wr_sel_t           sel,
  output logic              soft_rst
);
  always_comb begin
    sel       = '0;
    sel.cfg   = bus_wr && (bus_addr == OFF_CFG);
    sel.istat = bus_wr && (bus_addr == OFF_ISTAT);
    sel.ien   = bus_wr && (bus_addr == OFF_IEN);
    sel.wake  = bus_wr && (bus_addr == OFF_WAKE);
    sel.test  = bus_wr && (bus_addr == OFF_TEST);
    sel.ctrl  = bus_wr && (bus_addr == OFF_CTRL);
  end

  assign soft_rst = sel.cfg && bus_wdata[CFG_SRST_BIT];
endmodule

// File: rtl/spi_irq_cfgregs.sv
module spi_irq_cfgregs
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_sel_t           sel,
  input  logic              soft_rst,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] ien_q,
  output logic              wake_q,
  output logic [TEST_W-1:0] test_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [DATA_W-1:0] cfg_d, ien_d;
  logic              wake_d;
  logic [TEST_W-1:0] test_d;
  logic [CTRL_W-1:0] ctrl_d;

  // Next state: soft reset restores every register except the config word,
  // which takes the masked write data in the same cycle.
  always_comb begin
    cfg_d  = cfg_q;
    ien_d  = ien_q;
    wake_d = wake_q;
    test_d = test_q;
    ctrl_d = ctrl_q;
    if (soft_rst) begin
      ien_d  = '0;
      wake_d = 1'b0;
      test_d = '0;
      ctrl_d = CTRL_RST;
    end else begin
      if (sel.ien)  ien_d  = wdata & STAT_MASK;
      if (sel.wake) wake_d = wdata[0];
      if (sel.test) test_d = wdata[TEST_W-1:0];
      if (sel.ctrl) ctrl_d = wdata[CTRL_W-1:0];
    end
    if (sel.cfg) cfg_d = wdata & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ien_q  <= '0;
      wake_q <= 1'b0;
      test_q <= '0;
      ctrl_q <= CTRL_RST;
    end else begin
      cfg_q  <= cfg_d;
      ien_q  <= ien_d;
      wake_q <= wake_d;
      test_q <= test_d;
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tx_evt,
  input  logic [NCH-1:0]    rx_evt,
  input  logic              clr_wr,
  input  logic              clr_block,
  input  logic              force_all,
  input  logic              soft_rst,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stat_q
);
  localparam int LANE_W  = 4;
  localparam int RX_OFS  = 2;
  localparam int TOP_BIT = LANE_W * (NCH - 1) + RX_OFS;

  logic [DATA_W-1:0] evt_bits, clr_bits, force_bits, stat_d;

  // Per-channel lanes: each channel owns four status bit positions.
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    if ((g % LANE_W == 0) && (g / LANE_W < NCH)) begin : g_tx
      assign evt_bits[g] = tx_evt[g / LANE_W];
    end else if ((g % LANE_W == RX_OFS) && (g / LANE_W < NCH)) begin : g_rx
      assign evt_bits[g] = rx_evt[g / LANE_W];
    end else begin : g_none
      assign evt_bits[g] = 1'b0;
    end
  end

  assign clr_bits   = (clr_wr && !clr_block) ? wdata : '0;
  assign force_bits = force_all ? STAT_MASK : '0;

  // Events are ORed after the clear, so a same-cycle pulse wins.
  always_comb begin
    if (soft_rst) stat_d = '0;
    else          stat_d = ((stat_q & ~clr_bits) | evt_bits | force_bits) & STAT_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  initial begin
    if (TOP_BIT >= DATA_W) $error("spi_irq_status: NCH too large for status word");
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    tx_evt,
  input  logic [NCH-1:0]    rx_evt,
  output logic              irq_out
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  wr_sel_t           sel;
  logic              soft_rst;
  logic [DATA_W-1:0] cfg_q, ien_q, stat_q;
  logic              wake_q;
  logic [TEST_W-1:0] test_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              test_armed, force_all;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  spi_irq_decode u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sel      (sel),
    .soft_rst (soft_rst)
  );

  spi_irq_cfgregs u_cfg (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .sel     (sel),
    .soft_rst(soft_rst),
    .wdata   (bus_wdata),
    .cfg_q   (cfg_q),
    .ien_q   (ien_q),
    .wake_q  (wake_q),
    .test_q  (test_q),
    .ctrl_q  (ctrl_q)
  );

  assign test_armed = ctrl_q[CTRL_FORCE_BIT] && test_q[TEST_FORCE_BIT];
  assign force_all  = (sel.test && bus_wdata[TEST_FORCE_BIT] && ctrl_q[CTRL_FORCE_BIT])
                   || (sel.ctrl && bus_wdata[CTRL_FORCE_BIT] && test_q[TEST_FORCE_BIT]);

  spi_irq_status #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .tx_evt   (tx_evt),
    .rx_evt   (rx_evt),
    .clr_wr   (sel.istat),
    .clr_block(test_armed),
    .force_all(force_all),
    .soft_rst (soft_rst),
    .wdata    (bus_wdata),
    .stat_q   (stat_q)
  );

  always_comb begin
    case (bus_addr)
      OFF_REV:     bus_rdata = REV_VAL;
      OFF_CFG:     bus_rdata = cfg_q;
      OFF_RSTDONE: bus_rdata = 32'd1;
      OFF_ISTAT:   bus_rdata = stat_q;
      OFF_IEN:     bus_rdata = ien_q;
      OFF_WAKE:    bus_rdata = {{(DATA_W-1){1'b0}}, wake_q};
      OFF_TEST:    bus_rdata = {{(DATA_W-TEST_W){1'b0}}, test_q};
      OFF_CTRL:    bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      default:     bus_rdata = '0;
    endcase
  end

  assign irq_out = |(stat_q & ien_q);
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NCH-1:0]    tx_evt,
  input logic [NCH-1:0]    rx_evt,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] ien_q,
  input logic [TEST_W-1:0] test_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              irq_out
);
  logic srst_wr, armed;
  assign srst_wr = bus_wr && (bus_addr == OFF_CFG) && bus_wdata[CFG_SRST_BIT];
  assign armed   = ctrl_q[CTRL_FORCE_BIT] && test_q[TEST_FORCE_BIT];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assert_tx_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_evt[n] && !srst_wr) |=> stat_q[4*n]);
    assert_rx_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt[n] && !srst_wr) |=> stat_q[4*n+2]);
  end

  assert_ien_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_IEN) |=> (ien_q == ($past(bus_wdata) & STAT_MASK)));

  assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_out);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_ISTAT && !armed && tx_evt == '0 && rx_evt == '0)
    |=> ((stat_q & $past(bus_wdata)) == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && tx_evt == '0 && rx_evt == '0) |=> $stable(stat_q));

  assert_clr_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_ISTAT && armed) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_force_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_TEST && bus_wdata[TEST_FORCE_BIT] && ctrl_q[CTRL_FORCE_BIT])
    |=> (stat_q == STAT_MASK));

  assert_soft_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (stat_q == '0 && ien_q == '0 && test_q == '0 && ctrl_q == CTRL_RST));
endmodule

bind spi_irq_regs spi_irq_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .tx_evt   (tx_evt),
  .rx_evt   (rx_evt),
  .stat_q   (stat_q),
  .ien_q    (ien_q),
  .test_q   (test_q),
  .ctrl_q   (ctrl_q),
  .irq_out  (irq_out)
);

// File: tb/test_spi_irq_regs.sv
`timescale 1ns/1ps
module test_spi_irq_regs;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] tx_evt, rx_evt;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  spi_irq_regs #(.NCH(NCH)) i_spi_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .irq_out(irq_out)
  );

  // Each task drives one cycle, starting just after a rising edge.
  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] tx, input logic [NCH-1:0] rx);
    @(posedge clk); #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d; tx_evt = tx; rx_evt = rx;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0, '0);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
    item_t it;
    step(1'b0, a, 32'h0, '0, '0);
    it.is_irq = 0; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expect_irq(input bit e, input string req);
    item_t it;
    step(1'b0, 8'h00, 32'h0, '0, '0);
    it.is_irq = 1; it.exp = {31'b0, e}; it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: compares at the falling edge, mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: addr=%h actual=%h expected=%h", it.req, bus_addr, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; tx_evt = 0; rx_evt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Reset state and fixed words
    expect_rd(8'h00, 32'h91, "R9");
    expect_rd(8'h14, 32'h1, "R9");
    expect_rd(8'h28, 32'h4, "R7");
    expect_rd(8'h18, 32'h0, "R7");
    expect_rd(8'h1C, 32'h0, "R7");
    expect_rd(8'h24, 32'h0, "R7");
    expect_irq(1'b0, "R3");

    // Enable mask
    wr(8'h1C, 32'hFFFF_FFFF);
    expect_rd(8'h1C, 32'h0001_777F, "R2");
    wr(8'h1C, 32'h0);

    // Events: tx ch0, tx ch2, rx ch3 -> bits 0, 8, 14
    step(1'b0, 8'h00, 32'h0, 4'b0101, 4'b1000);
    expect_rd(8'h18, 32'h0000_4101, "R1");
    expect_irq(1'b0, "R3");
    wr(8'h1C, 32'h100);
    expect_irq(1'b1, "R3");

    // Write-one-to-clear
    wr(8'h18, 32'h100);
    expect_rd(8'h18, 32'h0000_4001, "R4");
    expect_irq(1'b0, "R3");

    // Event and clear of bit 4 in one cycle: set wins
    step(1'b1, 8'h18, 32'h10, 4'b0010, 4'b0000);
    expect_rd(8'h18, 32'h0000_4011, "R10");

    // Test bit without control bit: no force
    wr(8'h24, 32'hFFFF_F800);
    expect_rd(8'h24, 32'h800, "R7");
    expect_rd(8'h18, 32'h0000_4011, "R6");
    // Control bit 3 with test bit 11 already set: force
    wr(8'h28, 32'hFF);
    expect_rd(8'h28, 32'hF, "R7");
    expect_rd(8'h18, 32'h0001_777F, "R6");
    // Clear refused while armed
    wr(8'h18, 32'hFFFF_FFFF);
    expect_rd(8'h18, 32'h0001_777F, "R5");

    // Disarm, clear, then force through the test path
    wr(8'h28, 32'h4);
    wr(8'h18, 32'h0001_777F);
    expect_rd(8'h18, 32'h0, "R4");
    wr(8'h24, 32'h0);
    wr(8'h28, 32'h8);
    expect_rd(8'h18, 32'h0, "R6");
    wr(8'h24, 32'h800);
    expect_rd(8'h18, 32'h0001_777F, "R6");

    // Wakeup keeps bit 0
    wr(8'h20, 32'hFF);
    expect_rd(8'h20, 32'h1, "R7");

    // Undefined offset
    wr(8'h2C, 32'hFFFF_FFFF);
    expect_rd(8'h2C, 32'h0, "R11");
    expect_rd(8'h1C, 32'h100, "R11");
    expect_rd(8'h18, 32'h0001_777F, "R11");

    // Soft reset with events in the same cycle
    step(1'b1, 8'h10, 32'hFFFF_FFFF, 4'b1111, 4'b1111);
    expect_rd(8'h10, 32'h31D, "R8");
    expect_rd(8'h18, 32'h0, "R8");
    expect_rd(8'h1C, 32'h0, "R8");
    expect_rd(8'h28, 32'h4, "R8");
    expect_rd(8'h24, 32'h0, "R8");
    expect_rd(8'h20, 32'h0, "R8");
    expect_irq(1'b0, "R8");

    step(1'b0, 8'h00, 32'h0, '0, '0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule